// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block sits between a synchronous request port and an external asynchronous static RAM that holds 131,072 words of 24 bits. Each request carries a write flag, a 17-bit word address and 24 bits of write data. It becomes one read or one write cycle on the memory pins. The memory pins are the address, three chip enables (two active low, one active high), an active-low output enable, an active-low write enable, and a 24-bit data path. The data path is split into an outgoing value, an incoming value and a driver enable for the pad.

The length of each phase is a whole number of clock cycles, set by parameters: address-to-write-enable setup, write-enable pulse, and read access. The defaults suit a memory with 15 ns address access at a 100 MHz clock.

During a write, the output enable stays high. The controller's data drivers turn on only after the memory has had a full cycle to release the bus. The drivers stay on for one cycle after the write enable rises, so the data still meets setup and hold at that rising edge, which ends the write.

A read is always followed by one cycle with all enables inactive. This keeps the memory's outputs and the controller's drivers from driving the bus at the same time.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0, `rd_data` is 0, the output and write enables are 1, `mem_dq_oe` is 0, and the enables are in the deselected state.
- R2: The memory is selected only as the triple `mem_ce_a_n`=0, `mem_ce_b_n`=0, `mem_ce_c`=1, and only during the read access and the write phases. At all other times the triple is 1, 1, 0.
- R3: A write runs as follows after acceptance: `T_SETUP` cycles selected with the write enable high, then `T_WE` cycles with the write enable low, then one cycle selected with the write enable high. The output enable is high throughout the write.
- R4: `mem_dq_oe` is 1 from the second write-enable-low cycle through the cycle after the write enable rises, and 0 at all other times. While it is 1, `mem_dq_o` equals the accepted write data.
- R5: A read holds the memory selected with the output enable low and the write enable high for `T_RD` cycles. The drivers stay off.
- R6: `done` is high for exactly one cycle per request. After a read, that cycle immediately follows the access phase, and `rd_data` then holds the memory data sampled in the last access cycle. After a write, that cycle follows the hold cycle.
- R7: After a read, the controller spends one cycle deselected with the output enable high before it accepts a new request.
- R8: `req_ready` is 1 only when the controller is idle. A request presented while it is busy is ignored. Address and write data are captured at acceptance, so later changes on `req_addr` or `req_wdata` do not reach `mem_addr` or `mem_dq_o`.
- R9: A word written to an address is returned by a later read of that address, including at addresses 0 and 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 24 | Write data |
| req_ready | output | 1 | Controller idle and able to accept |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 24 | Registered read data |
| mem_addr | output | 17 | Memory address |
| mem_ce_a_n | output | 1 | Active-low chip enable |
| mem_ce_b_n | output | 1 | Second active-low chip enable |
| mem_ce_c | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_o | output | 24 | Data toward the memory |
| mem_dq_i | input | 24 | Data from the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |

## Verification
The properties assume that the request inputs and `mem_dq_i` hold known values once reset is released. They also assume that the request side is sampled only at rising edges, so a request raised while the controller is busy simply has no effect. The stimulus changes inputs only at falling edges and keeps them known. The bench's memory model returns the stored word, or zero, whenever it is selected with the output enable low. The stimulus deliberately raises `req_valid` while the controller is busy, and scrambles address and data right after acceptance, to show that nothing outside the idle state is sampled.

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl #(
  parameter int AW      = 17,
  parameter int DW      = 24,
  parameter int T_SETUP = 1,
  parameter int T_WE    = 2,
  parameter int T_RD    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_a_n,
  output logic          mem_ce_b_n,
  output logic          mem_ce_c,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_o,
  input  logic [DW-1:0] mem_dq_i,
  output logic          mem_dq_oe
);
  localparam int TMAX = (T_SETUP > T_WE) ? ((T_SETUP > T_RD) ? T_SETUP : T_RD)
                                         : ((T_WE > T_RD) ? T_WE : T_RD);
  localparam int CW = $clog2(TMAX + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WSET, ST_WPUL, ST_WHLD, ST_RACC, ST_TURN
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic [DW-1:0] rd_q;
  logic          done_q;
  logic          sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      a_q    <= '0;
      d_q    <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          a_q <= req_addr;
          d_q <= req_wdata;
          if (req_write) begin
            st  <= ST_WSET;
            cnt <= CW'(T_SETUP - 1);
          end else begin
            st  <= ST_RACC;
            cnt <= CW'(T_RD - 1);
          end
        end
        ST_WSET: if (cnt == '0) begin
          st  <= ST_WPUL;
          cnt <= CW'(T_WE - 1);
        end else cnt <= cnt - 1'b1;
        ST_WPUL: if (cnt == '0) st <= ST_WHLD;
                 else cnt <= cnt - 1'b1;
        ST_WHLD: begin
          st     <= ST_IDLE;
          done_q <= 1'b1;
        end
        ST_RACC: if (cnt == '0) begin
          st     <= ST_TURN;
          rd_q   <= mem_dq_i;
          done_q <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sel        = (st == ST_WSET) || (st == ST_WPUL) || (st == ST_WHLD) || (st == ST_RACC);
  assign req_ready  = (st == ST_IDLE);
  assign done       = done_q;
  assign rd_data    = rd_q;
  assign mem_addr   = a_q;
  assign mem_dq_o   = d_q;
  assign mem_ce_a_n = ~sel;
  assign mem_ce_b_n = ~sel;
  assign mem_ce_c   = sel;
  assign mem_oe_n   = (st != ST_RACC);
  assign mem_we_n   = (st != ST_WPUL);
  assign mem_dq_oe  = ((st == ST_WPUL) && (cnt != CW'(T_WE - 1))) || (st == ST_WHLD);
endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_a_n,
  input logic          mem_ce_b_n,
  input logic          mem_ce_c,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe
);
  logic on;
  assign on = !mem_ce_a_n && !mem_ce_b_n && mem_ce_c;

  AST_SEL_TRIPLE: assert property (@(posedge clk) disable iff (!rst_n)
    on || (mem_ce_a_n && mem_ce_b_n && !mem_ce_c)); // R2
  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R3
  AST_WE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> on); // R3
  AST_DRV_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !mem_dq_oe); // R4
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R4
  AST_READ_NO_DRV: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && on && !mem_dq_oe)); // R5
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (!on && !req_ready)); // R7
  AST_IDLE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!on && mem_we_n && !mem_dq_oe)); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (on && $past(on)) |-> $stable(mem_addr)); // R8
endmodule

bind sram_seq_ctrl sram_seq_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .mem_addr(mem_addr), .mem_ce_a_n(mem_ce_a_n), .mem_ce_b_n(mem_ce_b_n),
  .mem_ce_c(mem_ce_c), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_seq_ctrl_tb_top.sv
module sram_seq_ctrl_tb_top;
  localparam int AW = 17, DW = 24, S = 1, W = 2, R = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, done;
  logic [DW-1:0] rd_data, mem_dq_o, mem_dq_i;
  logic [AW-1:0] mem_addr;
  logic mem_ce_a_n, mem_ce_b_n, mem_ce_c, mem_oe_n, mem_we_n, mem_dq_oe;

  int total = 0, bad = 0, cycles = 0;

  always #10 clk = ~clk;

  sram_seq_ctrl #(.AW(AW), .DW(DW), .T_SETUP(S), .T_WE(W), .T_RD(R)) dut_i (.*);

  logic [DW-1:0] dev_mem [int];
  logic [DW-1:0] ref_mem [int];
  logic dev_sel, prev_we;
  assign dev_sel = !mem_ce_a_n && !mem_ce_b_n && mem_ce_c;

  function automatic logic [DW-1:0] rd_dev(input int a);
    return dev_mem.exists(a) ? dev_mem[a] : '0;
  endfunction
  function automatic logic [DW-1:0] rd_ref(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : '0;
  endfunction

  assign mem_dq_i = (dev_sel && !mem_oe_n && mem_we_n) ? rd_dev(int'(mem_addr)) : '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  // reference model
  int mode = 0, t = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0, exp_rd = '0;
  bit exp_done = 0, exp_rdv = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mode = 0; exp_done = 0; exp_rdv = 0; exp_rd = '0;
    end else begin
      exp_done = 0; exp_rdv = 0;
      case (mode)
        0: if (req_valid) begin
          mode = req_write ? 1 : 2; t = 0; m_addr = req_addr; m_data = req_wdata;
        end
        1: begin
          t++;
          if (t == S + W + 1) begin
            mode = 0; exp_done = 1; ref_mem[int'(m_addr)] = m_data;
          end
        end
        2: begin
          t++;
          if (t == R) begin
            mode = 3; exp_done = 1; exp_rdv = 1; exp_rd = rd_ref(int'(m_addr));
          end
        end
        default: mode = 0;
      endcase
    end
  end

  // device write capture and per-cycle comparison
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      bit e_sel, e_we_n, e_drv;
      if (prev_we == 1'b0 && mem_we_n && dev_sel && mem_dq_oe)
        dev_mem[int'(mem_addr)] = mem_dq_o;
      e_sel  = (mode == 1) || (mode == 2);
      e_we_n = !(mode == 1 && t >= S && t < S + W);
      e_drv  = (mode == 1) && (t > S) && (t <= S + W);
      chk(req_ready == (mode == 0), "R8 ready", {31'd0, req_ready}, {31'd0, mode == 0});
      chk(mem_ce_a_n == !e_sel && mem_ce_b_n == !e_sel && mem_ce_c == e_sel, "R2 enables",
          {29'd0, mem_ce_a_n, mem_ce_b_n, mem_ce_c}, {29'd0, !e_sel, !e_sel, e_sel});
      chk(mem_we_n == e_we_n, "R3 we_n", {31'd0, mem_we_n}, {31'd0, e_we_n});
      chk(mem_oe_n == !(mode == 2), "R5 oe_n", {31'd0, mem_oe_n}, {31'd0, !(mode == 2)});
      chk(mem_dq_oe == e_drv, "R4 drive", {31'd0, mem_dq_oe}, {31'd0, e_drv});
      if (e_sel) chk(mem_addr == m_addr, "R8 addr", {15'd0, mem_addr}, {15'd0, m_addr});
      if (e_drv) chk(mem_dq_o == m_data, "R4 data", {8'd0, mem_dq_o}, {8'd0, m_data});
      chk(done == exp_done, "R6 done", {31'd0, done}, {31'd0, exp_done});
      if (exp_rdv) chk(rd_data == exp_rd, "R9 rd_data", {8'd0, rd_data}, {8'd0, exp_rd});
      if (mode == 3) chk(!dev_sel && mem_oe_n, "R7 turn", {31'd0, dev_sel}, 32'd0);
    end
    prev_we = mem_we_n;
  end

  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_addr = ~a; req_wdata = ~d;
  endtask

  task automatic poke_busy();
    if (!req_ready) begin
      req_valid = 1; req_write = ~req_write; req_addr = 17'h0AAAA; req_wdata = 24'h5A5A5A;
      @(negedge clk);
      req_valid = 0;
    end
  endtask

  initial begin
    logic [31:0] lcg;
    lcg = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(req_ready && !done && rd_data == '0 && mem_we_n && mem_oe_n && !mem_dq_oe
        && mem_ce_a_n && mem_ce_b_n && !mem_ce_c, "R1 reset", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    issue(1, 17'h00000, 24'hFFFFFF);
    poke_busy();
    issue(1, 17'h1FFFF, 24'hA5A5A5);
    issue(1, 17'h12345, 24'h000001);
    issue(0, 17'h00000, 24'h0);
    poke_busy();
    issue(1, 17'h00000, 24'h123456);
    issue(0, 17'h1FFFF, 24'h0);
    issue(0, 17'h00000, 24'h0);
    issue(0, 17'h12345, 24'h0);
    issue(0, 17'h00777, 24'h0);
    for (int i = 0; i < 24; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      issue(1, lcg[AW-1:0] & 17'h0003F, lcg[31:8]);
      if (i[0]) poke_busy();
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      issue(0, lcg[AW-1:0] & 17'h0003F, 24'h0);
    end
    while (!req_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, actual=%0d expected<=20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule